// File: doc/BRIEF.md
# Programmable-Polynomial Byte CRC Engine

This block accumulates a cyclic redundancy check over a byte stream, such as the stream a DMA engine moves between memory regions. It consumes one byte on every cycle its valid input is high and folds it into a 32-bit partial-result register. The generator polynomial and the starting value are both loaded at run time. The CRC is computed MSB-first, so the block serves any CRC width from 1 to 32 bits. A CRC narrower than 32 bits places its polynomial and starting value in the most significant bits and zeros below them. Its result then appears in the same high bits of the 32-bit output.

Two definition slots hold the CRC parameters. Each slot is written as one 64-bit word: the starting value in bits 31:0 and the polynomial in bits 63:32. A move opens with a one-cycle start strobe. The strobe selects a slot and carries a clear flag. When the flag is set, the partial result is reloaded from that slot's starting value. When it is clear, the new move continues from the present partial result, using the newly selected slot's polynomial. A byte that arrives in the same cycle as a clearing start is folded into the freshly loaded value. The partial result can be read on the output at any time.

Top module: `crc_engine`

## Requirements
- R1: While `rst` is high on a clock edge, the partial result becomes 0 after that edge. The selected slot returns to slot 0, and both definition slots return to 0.
- R2: A write with `def_we` high stores `def_wdata` in slot `def_wsel`. Bits 31:0 are the starting value and bits 63:32 are the polynomial. The new contents are used from the following cycle on.
- R3: `mv_start` with `mv_clr` high and `dat_valid` low sets `crc_out` to the starting value of slot `mv_sel` one cycle later.
- R4: Each cycle with `dat_valid` high folds `dat_byte` into the partial result MSB-first, bit 7 first. For each bit, the register shifts left by one. When the old bit 31 XOR the data bit is 1, the polynomial is XORed in. The result is visible on `crc_out` one cycle later.
- R5: When both `dat_valid` and `mv_start` are low, `crc_out` holds its value.
- R6: `mv_start` with `mv_clr` low keeps the partial result. From that cycle on, including any byte in the same cycle, bytes use the polynomial of slot `mv_sel`.
- R7: When `mv_start`, `mv_clr` and `dat_valid` are all high in one cycle, the byte is folded into the selected slot's starting value, not into the old partial result.
- R8: When the polynomial and the starting value have their low bits zero, those low bits of `crc_out` stay zero. A narrow CRC therefore reads out in the high bits.
- R9: Writing one slot leaves the other slot's contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| def_we | input | 1 | Write strobe for a definition slot |
| def_wsel | input | 1 | Slot index for the write |
| def_wdata | input | 64 | Slot contents: starting value in bits 31:0, polynomial in bits 63:32 |
| mv_start | input | 1 | One-cycle strobe that opens a move |
| mv_sel | input | 1 | Slot used by the move being opened |
| mv_clr | input | 1 | Reload the partial result from the slot's starting value |
| dat_valid | input | 1 | A data byte is present this cycle |
| dat_byte | input | 8 | Data byte, processed bit 7 first |
| crc_out | output | 32 | Current partial result |

## Verification
The assertions check four behaviours on every cycle. A reset edge leaves a zero result. An idle cycle keeps the result stable. A clearing start without data loads the starting value, which the checker tracks from the write port. A non-clearing start without data leaves the result unchanged. The byte arithmetic itself cannot be checked cycle by cycle, and the bench's scenarios are the only evidence for it. These scenarios cover three standard check values over the string "123456789", at widths 8, 16 and 32. They also cover a polynomial switch in mid-stream, a clear that coincides with data, and the independence of the two slots.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;

    localparam int ACC_W  = 32;
    localparam int BYTE_W = 8;
    localparam int DEF_W  = 2 * ACC_W;

    // Packed so that the polynomial occupies the upper half of the word
    typedef struct packed {
        logic [ACC_W-1:0] poly;
        logic [ACC_W-1:0] seed;
    } crc_def_t;

    // One MSB-first bit step of a left-shifting CRC register
    function automatic logic [ACC_W-1:0] crc_bit_step(
        input logic [ACC_W-1:0] acc,
        input logic             din,
        input logic [ACC_W-1:0] poly
    );
        logic fb;
        fb = acc[ACC_W-1] ^ din;
        return {acc[ACC_W-2:0], 1'b0} ^ (fb ? poly : '0);
    endfunction

endpackage

// File: rtl/crc_def_bank.sv
module crc_def_bank
    import crc_eng_pkg::*;
#(
    parameter int NUM_DEFS = 2,
    localparam int SEL_W = (NUM_DEFS > 1) ? $clog2(NUM_DEFS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SEL_W-1:0] wsel,
    input  crc_def_t         wdata,
    input  logic [SEL_W-1:0] rsel,
    output crc_def_t         rdef
);

    crc_def_t slot_q [NUM_DEFS];

    for (genvar g = 0; g < NUM_DEFS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[g] <= '0;
            end else if (we && (wsel == SEL_W'(g))) begin
                slot_q[g] <= wdata;
            end
        end
    end

    assign rdef = slot_q[rsel];

endmodule

// File: rtl/crc_byte_stage.sv
module crc_byte_stage
    import crc_eng_pkg::*;
(
    input  logic [ACC_W-1:0]  acc_in,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [ACC_W-1:0]  poly,
    output logic [ACC_W-1:0]  acc_out
);

    // chain[0] is the input; chain[k+1] follows the k-th bit, MSB first
    logic [ACC_W-1:0] chain [BYTE_W+1];

    assign chain[0] = acc_in;

    for (genvar k = 0; k < BYTE_W; k++) begin : g_bit
        assign chain[k+1] = crc_bit_step(chain[k], byte_in[BYTE_W-1-k], poly);
    end

    assign acc_out = chain[BYTE_W];

endmodule

// File: rtl/crc_engine.sv
module crc_engine
    import crc_eng_pkg::*;
#(
    parameter int NUM_DEFS = 2,
    localparam int SEL_W = (NUM_DEFS > 1) ? $clog2(NUM_DEFS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              def_we,
    input  logic [SEL_W-1:0]  def_wsel,
    input  logic [DEF_W-1:0]  def_wdata,
    input  logic              mv_start,
    input  logic [SEL_W-1:0]  mv_sel,
    input  logic              mv_clr,
    input  logic              dat_valid,
    input  logic [BYTE_W-1:0] dat_byte,
    output logic [ACC_W-1:0]  crc_out
);

    logic [ACC_W-1:0] acc_q;
    logic [SEL_W-1:0] act_sel_q;
    logic [SEL_W-1:0] use_sel;
    crc_def_t         cur_def;
    logic             do_load;
    logic [ACC_W-1:0] base_acc;
    logic [ACC_W-1:0] next_acc;

    crc_def_bank #(.NUM_DEFS(NUM_DEFS)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (def_we),
        .wsel  (def_wsel),
        .wdata (crc_def_t'(def_wdata)),
        .rsel  (use_sel),
        .rdef  (cur_def)
    );

    // A start strobe switches the slot at once; otherwise the move's slot holds
    assign use_sel  = mv_start ? mv_sel : act_sel_q;
    assign do_load  = mv_start && mv_clr;
    assign base_acc = do_load ? cur_def.seed : acc_q;

    crc_byte_stage u_stage (
        .acc_in  (base_acc),
        .byte_in (dat_byte),
        .poly    (cur_def.poly),
        .acc_out (next_acc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            act_sel_q <= '0;
        end else begin
            if (mv_start) begin
                act_sel_q <= mv_sel;
            end
            if (dat_valid) begin
                acc_q <= next_acc;
            end else if (do_load) begin
                acc_q <= cur_def.seed;
            end
        end
    end

    assign crc_out = acc_q;

endmodule

// File: rtl/crc_engine_chk.sv
module crc_engine_chk
    import crc_eng_pkg::*;
#(
    parameter int NUM_DEFS = 2,
    localparam int SEL_W = (NUM_DEFS > 1) ? $clog2(NUM_DEFS) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              def_we,
    input logic [SEL_W-1:0]  def_wsel,
    input logic [DEF_W-1:0]  def_wdata,
    input logic              mv_start,
    input logic [SEL_W-1:0]  mv_sel,
    input logic              mv_clr,
    input logic              dat_valid,
    input logic [BYTE_W-1:0] dat_byte,
    input logic [ACC_W-1:0]  crc_out
);

    // Shadow of the starting values, rebuilt from the write port alone
    logic [ACC_W-1:0] seed_sh [NUM_DEFS];
    logic [ACC_W-1:0] want_seed;

    for (genvar g = 0; g < NUM_DEFS; g++) begin : g_sh
        always_ff @(posedge clk) begin
            if (rst) begin
                seed_sh[g] <= '0;
            end else if (def_we && (def_wsel == SEL_W'(g))) begin
                seed_sh[g] <= def_wdata[ACC_W-1:0];
            end
        end
    end

    assign want_seed = seed_sh[mv_sel];

    AST_RESET_ZERO: assert property (@(posedge clk)
        rst |=> (crc_out == '0)); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!mv_start && !dat_valid) |=> $stable(crc_out)); // R5

    AST_CLEAR_LOAD: assert property (@(posedge clk) disable iff (rst)
        (mv_start && mv_clr && !dat_valid) |=> (crc_out == $past(want_seed))); // R3

    AST_CONTINUE_KEEP: assert property (@(posedge clk) disable iff (rst)
        (mv_start && !mv_clr && !dat_valid) |=> $stable(crc_out)); // R6

endmodule

bind crc_engine crc_engine_chk #(.NUM_DEFS(NUM_DEFS)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .def_we    (def_we),
    .def_wsel  (def_wsel),
    .def_wdata (def_wdata),
    .mv_start  (mv_start),
    .mv_sel    (mv_sel),
    .mv_clr    (mv_clr),
    .dat_valid (dat_valid),
    .dat_byte  (dat_byte),
    .crc_out   (crc_out)
);

// File: tb/test_crc_engine.sv
`timescale 1ns/1ps
module test_crc_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        def_we = 1'b0;
    logic [0:0]  def_wsel = '0;
    logic [63:0] def_wdata = '0;
    logic        mv_start = 1'b0;
    logic [0:0]  mv_sel = '0;
    logic        mv_clr = 1'b0;
    logic        dat_valid = 1'b0;
    logic [7:0]  dat_byte = '0;
    logic [31:0] crc_out;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    crc_engine i_crc_engine (
        .clk(clk), .rst(rst), .def_we(def_we), .def_wsel(def_wsel),
        .def_wdata(def_wdata), .mv_start(mv_start), .mv_sel(mv_sel),
        .mv_clr(mv_clr), .dat_valid(dat_valid), .dat_byte(dat_byte),
        .crc_out(crc_out)
    );

    typedef struct packed {
        logic [31:0] poly;
        logic [31:0] seed;
        logic [31:0] expect_v;
        logic [31:0] low_mask;
    } vec_t;

    // Standard check values over "123456789", MSB-first, no final XOR
    localparam vec_t VECS [3] = '{
        '{32'h04C1_1DB7, 32'hFFFF_FFFF, 32'h0376_E6E7, 32'h0000_0000},
        '{32'h1021_0000, 32'hFFFF_0000, 32'h29B1_0000, 32'h0000_FFFF},
        '{32'h0700_0000, 32'h0000_0000, 32'hF400_0000, 32'h00FF_FFFF}
    };

    function automatic logic [31:0] ref_byte(input logic [31:0] a,
                                             input logic [7:0] b,
                                             input logic [31:0] p);
        logic [31:0] r;
        r = a;
        for (int i = 7; i >= 0; i--) begin
            if (r[31] ^ b[i]) r = (r << 1) ^ p;
            else              r = r << 1;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs at the falling edge, sample 1 ns after the rising edge
    task automatic cyc(input logic st, input logic sel, input logic clr,
                       input logic vld, input logic [7:0] b);
        @(negedge clk);
        mv_start = st; mv_sel = sel; mv_clr = clr; dat_valid = vld; dat_byte = b;
        def_we = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic wr_def(input logic sel, input logic [31:0] poly, input logic [31:0] seed);
        @(negedge clk);
        mv_start = 0; dat_valid = 0;
        def_we = 1'b1; def_wsel = sel; def_wdata = {poly, seed};
        @(posedge clk);
        #1;
        @(negedge clk);
        def_we = 1'b0;
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 8'h00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] acc;
        logic [31:0] hold;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset value", crc_out, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        idle();
        check("R1 after reset idle", crc_out, 32'h0);

        // Table walk: clear and first byte together (R7), then the rest (R4, R8)
        for (int v = 0; v < 3; v++) begin
            wr_def(v[0], VECS[v].poly, VECS[v].seed);
            cyc(1, v[0], 1, 1, 8'h31);
            for (int k = 2; k <= 9; k++) cyc(0, 0, 0, 1, 8'h30 + 8'(k));
            idle();
            check("R4 R2 R7 check value", crc_out, VECS[v].expect_v);
            check("R8 low bits zero", crc_out & VECS[v].low_mask, 32'h0);
        end

        // R5: idle cycles keep the result
        hold = crc_out;
        repeat (3) idle();
        check("R5 idle hold", crc_out, hold);

        // R3: clearing start without data loads the starting value
        wr_def(0, 32'h04C1_1DB7, 32'h1234_5678);
        cyc(1, 0, 1, 0, 8'hAA);
        check("R3 clear loads seed", crc_out, 32'h1234_5678);
        cyc(0, 0, 0, 1, 8'hC3);
        check("R4 single byte", crc_out, ref_byte(32'h1234_5678, 8'hC3, 32'h04C1_1DB7));

        // R9: rewriting slot 0 leaves slot 1 intact
        wr_def(1, 32'h8005_0000, 32'hABCD_0000);
        wr_def(0, 32'h0000_0007, 32'h5555_5555);
        cyc(1, 1, 1, 0, 8'h00);
        check("R9 slot 1 kept", crc_out, 32'hABCD_0000);
        cyc(1, 0, 1, 0, 8'h00);
        check("R9 slot 0 rewritten R2", crc_out, 32'h5555_5555);

        // R6: continue without clear, switching polynomial in mid stream
        cyc(0, 0, 0, 1, 8'h5A);
        acc = ref_byte(32'h5555_5555, 8'h5A, 32'h0000_0007);
        check("R4 slot 0 byte", crc_out, acc);
        hold = crc_out;
        cyc(1, 1, 0, 0, 8'hFF);
        check("R6 start without clear keeps", crc_out, hold);
        cyc(0, 0, 0, 1, 8'h96);
        acc = ref_byte(acc, 8'h96, 32'h8005_0000);
        check("R6 uses new slot poly", crc_out, acc);
        cyc(1, 0, 0, 1, 8'h3C);
        acc = ref_byte(acc, 8'h3C, 32'h0000_0007);
        check("R6 same-cycle switch byte", crc_out, acc);

        // R7: clear with data on a non-zero result ignores the old value
        cyc(1, 1, 1, 1, 8'h81);
        check("R7 clear with data", crc_out, ref_byte(32'hABCD_0000, 8'h81, 32'h8005_0000));

        // R1: reset mid stream clears result and slots
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset mid stream", crc_out, 32'h0);
        cyc(1, 1, 1, 0, 8'h00);
        check("R1 slots cleared", crc_out, 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule